// File: doc/BRIEF.md
# Packed Vector Instruction Fault Resolver

This block sits in front of the issue stage for packed floating-point vector instructions. When the pipeline raises a check request, the block looks at the control-register bits, the feature-present flag, the lock prefix, the operating mode, and the memory-access status lines. It also looks at any unmasked floating-point exception reported by the execution unit. From these it selects the single fault that the instruction takes, if any.

The result is registered. One clock edge after the request it appears as a one-hot fault vector, a one-cycle fault-valid pulse and, for page faults, the fault code passed through. Each fault class has a fixed priority, so when several conditions hold at once, only the most important one is reported. Address translation and delivery of the trap are left to neighbouring logic.

Top module: `simd_fault_check`

## Requirements
- R1: While reset (`rstN` low) is asserted and after it is released, `faultVec`, `faultValid` and `faultCode` are all zero until the first request.
- R2: Outputs change only on the clock edge that samples `checkReq` high. `faultValid` is high for exactly that one cycle when a fault is chosen. With `checkReq` low, `faultVec` and `faultCode` keep their values and `faultValid` is low.
- R3: `faultVec` bit 0 (undefined opcode) is chosen at top priority when any of these holds: `lockPrefix` is high, `emulate` is high, `osSaveOk` is low, or `featPresent` is low.
- R4: When no R3 condition holds, `taskSwitched` high selects `faultVec` bit 1 (device not available).
- R5: When neither R3 nor R4 applies, `misaligned` high selects `faultVec` bit 2 (general protection) in either mode. This takes precedence over a stack-segment limit fault.
- R6: In protected mode (`realMode` low), `limitViol` with `stackSeg` high selects bit 3 (stack fault), and `limitViol` with `stackSeg` low selects bit 2. `beyondReal` has no effect in this mode.
- R7: In real mode, `beyondReal` high selects bit 2. `limitViol` and `stackSeg` have no effect in this mode, and no stack fault is raised.
- R8: Below the segment checks, `pageFault` selects bit 4 (page fault) and `faultCode` takes `pageCode`. For every other outcome `faultCode` is zero.
- R9: At lowest priority, `fpExc` selects bit 5 (vector floating-point fault) when `osExcOk` is high, and bit 0 when `osExcOk` is low.
- R10: When `faultValid` is high, exactly one bit of `faultVec` is set. A request with no fault condition clears `faultVec` and leaves `faultValid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| checkReq | input | 1 | Evaluate the current condition inputs |
| lockPrefix | input | 1 | Instruction carries a lock prefix |
| taskSwitched | input | 1 | Task-switched control bit |
| emulate | input | 1 | Emulation control bit |
| osSaveOk | input | 1 | OS supports vector state save/restore |
| osExcOk | input | 1 | OS handles vector floating-point exceptions |
| featPresent | input | 1 | Vector feature is implemented |
| realMode | input | 1 | 1 = real-address mode, 0 = protected mode |
| misaligned | input | 1 | Memory operand is not 16-byte aligned |
| limitViol | input | 1 | Effective address is outside the segment limit |
| stackSeg | input | 1 | The limit check was for the stack segment |
| beyondReal | input | 1 | An operand byte lies above 0xFFFF |
| pageFault | input | 1 | Translation reported a page fault |
| pageCode | input | CODE_W | Page fault code |
| fpExc | input | 1 | Unmasked floating-point exception from execution |
| faultVec | output | 6 | One-hot fault: bit0 undef, bit1 dev-n/a, bit2 GP, bit3 stack, bit4 page, bit5 vector FP |
| faultValid | output | 1 | One-cycle pulse when a fault is chosen |
| faultCode | output | CODE_W | Page fault code, zero otherwise |

## Verification
The bench uses the default `CODE_W` of 16. It drives page codes with alternating bit patterns across the full width, so a dropped or shifted code bit shows up. Since the other widths are fixed by the fault set, the scenarios focus on pairs of simultaneous conditions that straddle every priority boundary. They also cover the mode-dependent inputs that must be ignored in the opposite mode.

// File: rtl/simd_fault_pkg.sv
package simd_fault_pkg;
  localparam int NUM_FAULTS  = 6;
  localparam int IDX_UNDEF   = 0;
  localparam int IDX_DEVNA   = 1;
  localparam int IDX_GENPROT = 2;
  localparam int IDX_STACK   = 3;
  localparam int IDX_PAGE    = 4;
  localparam int IDX_VECFP   = 5;

  typedef struct packed {
    logic                  load;
    logic                  raise;
    logic [NUM_FAULTS-1:0] pick;
    logic                  takeCode;
  } ctlStrobe_t;
endpackage

// File: rtl/simd_fault_ctrl.sv
module simd_fault_ctrl
  import simd_fault_pkg::*;
(
  input  logic       checkReq,
  input  logic       lockPrefix,
  input  logic       taskSwitched,
  input  logic       emulate,
  input  logic       osSaveOk,
  input  logic       osExcOk,
  input  logic       featPresent,
  input  logic       realMode,
  input  logic       misaligned,
  input  logic       limitViol,
  input  logic       stackSeg,
  input  logic       beyondReal,
  input  logic       pageFault,
  input  logic       fpExc,
  output ctlStrobe_t strobe
);
  logic undefDecode;
  logic segGenProt;
  logic segStack;
  logic [NUM_FAULTS-1:0] pickVec;

  // decode-time undefined conditions (R3)
  assign undefDecode = lockPrefix | emulate | ~osSaveOk | ~featPresent;

  // segment tier: alignment first, then mode-dependent limit checks (R5-R7)
  always_comb begin
    segGenProt = 1'b0;
    segStack   = 1'b0;
    if (misaligned) begin
      segGenProt = 1'b1;
    end else if (realMode) begin
      segGenProt = beyondReal;
    end else if (limitViol) begin
      segStack   = stackSeg;
      segGenProt = ~stackSeg;
    end
  end

  // priority chain across tiers
  always_comb begin
    pickVec = '0;
    if (undefDecode)       pickVec[IDX_UNDEF]   = 1'b1;
    else if (taskSwitched) pickVec[IDX_DEVNA]   = 1'b1;
    else if (segGenProt)   pickVec[IDX_GENPROT] = 1'b1;
    else if (segStack)     pickVec[IDX_STACK]   = 1'b1;
    else if (pageFault)    pickVec[IDX_PAGE]    = 1'b1;
    else if (fpExc) begin
      if (osExcOk) pickVec[IDX_VECFP] = 1'b1;
      else         pickVec[IDX_UNDEF] = 1'b1;
    end
  end

  always_comb begin
    strobe.load     = checkReq;
    strobe.pick     = pickVec;
    strobe.raise    = checkReq & (|pickVec);
    strobe.takeCode = checkReq & pickVec[IDX_PAGE];
  end

  // R10: the resolver never selects more than one class
  always_comb begin
    a_r10_pick_single: assert ($countones(pickVec) <= 1)
      else $error("resolver selected several faults");
  end
endmodule

// File: rtl/simd_fault_dp.sv
module simd_fault_dp
  import simd_fault_pkg::*;
#(
  parameter int CODE_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctlStrobe_t            strobe,
  input  logic [CODE_W-1:0]     pageCode,
  output logic [NUM_FAULTS-1:0] faultVec,
  output logic                  faultValid,
  output logic [CODE_W-1:0]     faultCode
);
  logic [NUM_FAULTS-1:0] vecQ;
  logic                  validQ;
  logic [CODE_W-1:0]     codeQ;

  for (genvar g = 0; g < NUM_FAULTS; g++) begin : g_vecBit
    always_ff @(posedge clk) begin
      if (!rstN)            vecQ[g] <= 1'b0;
      else if (strobe.load) vecQ[g] <= strobe.pick[g];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= 1'b0;
      codeQ  <= '0;
    end else begin
      validQ <= strobe.raise;
      if (strobe.load) codeQ <= strobe.takeCode ? pageCode : '0;
    end
  end

  assign faultVec   = vecQ;
  assign faultValid = validQ;
  assign faultCode  = codeQ;

  a_r2_valid_follows_load: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |-> $past(strobe.load))
    else $error("valid without preceding request");

  a_r8_code_only_page: assert property (@(posedge clk) disable iff (!rstN)
    !faultVec[IDX_PAGE] |-> faultCode == '0)
    else $error("code present without page fault");
endmodule

// File: rtl/simd_fault_check.sv
module simd_fault_check
  import simd_fault_pkg::*;
#(
  parameter int CODE_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  checkReq,
  input  logic                  lockPrefix,
  input  logic                  taskSwitched,
  input  logic                  emulate,
  input  logic                  osSaveOk,
  input  logic                  osExcOk,
  input  logic                  featPresent,
  input  logic                  realMode,
  input  logic                  misaligned,
  input  logic                  limitViol,
  input  logic                  stackSeg,
  input  logic                  beyondReal,
  input  logic                  pageFault,
  input  logic [CODE_W-1:0]     pageCode,
  input  logic                  fpExc,
  output logic [NUM_FAULTS-1:0] faultVec,
  output logic                  faultValid,
  output logic [CODE_W-1:0]     faultCode
);
  ctlStrobe_t strobe;

  simd_fault_ctrl u_ctrl (
    .checkReq     (checkReq),
    .lockPrefix   (lockPrefix),
    .taskSwitched (taskSwitched),
    .emulate      (emulate),
    .osSaveOk     (osSaveOk),
    .osExcOk      (osExcOk),
    .featPresent  (featPresent),
    .realMode     (realMode),
    .misaligned   (misaligned),
    .limitViol    (limitViol),
    .stackSeg     (stackSeg),
    .beyondReal   (beyondReal),
    .pageFault    (pageFault),
    .fpExc        (fpExc),
    .strobe       (strobe)
  );

  simd_fault_dp #(.CODE_W(CODE_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .pageCode   (pageCode),
    .faultVec   (faultVec),
    .faultValid (faultValid),
    .faultCode  (faultCode)
  );

  a_r10_valid_onehot: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |-> $onehot(faultVec))
    else $error("valid fault vector not one-hot");

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !checkReq |=> $stable(faultVec) && $stable(faultCode) && !faultValid)
    else $error("outputs moved without request");

  a_r3_lock_undef: assert property (@(posedge clk) disable iff (!rstN)
    checkReq && lockPrefix |=> faultValid && faultVec[IDX_UNDEF])
    else $error("lock prefix did not raise undefined opcode");

  a_r4_devna: assert property (@(posedge clk) disable iff (!rstN)
    checkReq && taskSwitched && !lockPrefix && !emulate && osSaveOk && featPresent
      |=> faultValid && faultVec[IDX_DEVNA])
    else $error("task-switched did not raise device not available");

  a_r9_fp_route: assert property (@(posedge clk) disable iff (!rstN)
    checkReq && fpExc && !osExcOk |=> faultValid && !faultVec[IDX_VECFP])
    else $error("fp exception routed to vector fault without OS support");
endmodule

// File: tb/simd_fault_check_bench.sv
`timescale 1ns/1ps
module simd_fault_check_bench;
  localparam int CODE_W = 16;

  logic clk = 1'b0;
  logic rstN;
  logic checkReq, lockPrefix, taskSwitched, emulate, osSaveOk, osExcOk;
  logic featPresent, realMode, misaligned, limitViol, stackSeg, beyondReal;
  logic pageFault, fpExc;
  logic [CODE_W-1:0] pageCode;
  logic [5:0]        faultVec;
  logic              faultValid;
  logic [CODE_W-1:0] faultCode;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  simd_fault_check #(.CODE_W(CODE_W)) u_simd_fault_check (
    .clk(clk), .rstN(rstN), .checkReq(checkReq), .lockPrefix(lockPrefix),
    .taskSwitched(taskSwitched), .emulate(emulate), .osSaveOk(osSaveOk),
    .osExcOk(osExcOk), .featPresent(featPresent), .realMode(realMode),
    .misaligned(misaligned), .limitViol(limitViol), .stackSeg(stackSeg),
    .beyondReal(beyondReal), .pageFault(pageFault), .pageCode(pageCode),
    .fpExc(fpExc), .faultVec(faultVec), .faultValid(faultValid),
    .faultCode(faultCode)
  );

  task automatic clean();
    lockPrefix = 0; taskSwitched = 0; emulate = 0; osSaveOk = 1; osExcOk = 1;
    featPresent = 1; realMode = 0; misaligned = 0; limitViol = 0; stackSeg = 0;
    beyondReal = 0; pageFault = 0; fpExc = 0; pageCode = '0;
  endtask

  task automatic expect_out(input logic [5:0] eVec, input logic eValid,
                            input logic [CODE_W-1:0] eCode, input string tag);
    checks++;
    if (faultVec !== eVec || faultValid !== eValid || faultCode !== eCode) begin
      fails++;
      $display("FAIL %s: vec=%b valid=%b code=%h expected vec=%b valid=%b code=%h",
               tag, faultVec, faultValid, faultCode, eVec, eValid, eCode);
    end
  endtask

  // inputs already set at a negedge; pulse request, sample after the edge
  task automatic request(input logic [5:0] eVec, input logic [CODE_W-1:0] eCode,
                         input string tag);
    checkReq = 1'b1;
    @(negedge clk);
    checkReq = 1'b0;
    expect_out(eVec, |eVec, eCode, tag);
    clean();
  endtask

  task automatic t_reset();
    expect_out(6'b000000, 1'b0, '0, "R1 reset state");
  endtask

  task automatic t_no_fault();
    request(6'b000000, '0, "R10 no condition");
  endtask

  task automatic t_decode_undef();
    lockPrefix = 1; taskSwitched = 1; pageFault = 1; pageCode = 16'h1234;
    request(6'b000001, '0, "R3 lock over others");
    emulate = 1; misaligned = 1;
    request(6'b000001, '0, "R3 emulate");
    osSaveOk = 0; fpExc = 1;
    request(6'b000001, '0, "R3 os save support clear");
    featPresent = 0; limitViol = 1; stackSeg = 1;
    request(6'b000001, '0, "R3 feature absent");
  endtask

  task automatic t_devna();
    taskSwitched = 1; misaligned = 1; pageFault = 1; fpExc = 1;
    request(6'b000010, '0, "R4 task switched over GP/page/fp");
  endtask

  task automatic t_align();
    misaligned = 1; limitViol = 1; stackSeg = 1;
    request(6'b000100, '0, "R5 misaligned over stack fault");
    realMode = 1; misaligned = 1; pageFault = 1; pageCode = 16'h00FF;
    request(6'b000100, '0, "R5 misaligned in real mode");
  endtask

  task automatic t_prot_limit();
    limitViol = 1; stackSeg = 1; pageFault = 1; pageCode = 16'h5555;
    request(6'b001000, '0, "R6 stack segment limit");
    limitViol = 1;
    request(6'b000100, '0, "R6 data segment limit");
    beyondReal = 1;
    request(6'b000000, '0, "R6 beyondReal ignored in protected mode");
  endtask

  task automatic t_real_limit();
    realMode = 1; beyondReal = 1;
    request(6'b000100, '0, "R7 beyond 64K in real mode");
    realMode = 1; limitViol = 1; stackSeg = 1;
    request(6'b000000, '0, "R7 limit ignored in real mode");
  endtask

  task automatic t_page();
    pageFault = 1; pageCode = 16'hA5C3; fpExc = 1;
    request(6'b010000, 16'hA5C3, "R8 page over fp, code A5C3");
    pageFault = 1; pageCode = 16'h5A3C;
    request(6'b010000, 16'h5A3C, "R8 code 5A3C");
    taskSwitched = 1; pageFault = 1; pageCode = 16'hFFFF;
    request(6'b000010, '0, "R8 code cleared when not page");
  endtask

  task automatic t_fp();
    fpExc = 1; osExcOk = 1;
    request(6'b100000, '0, "R9 fp with OS support");
    fpExc = 1; osExcOk = 0;
    request(6'b000001, '0, "R9 fp without OS support");
  endtask

  task automatic t_timing();
    pageFault = 1; pageCode = 16'hC0DE;
    request(6'b010000, 16'hC0DE, "R2 fault on request edge");
    taskSwitched = 1;
    @(negedge clk);
    expect_out(6'b010000, 1'b0, 16'hC0DE, "R2 hold without request");
    clean();
    request(6'b000000, '0, "R2 R10 clean request clears");
  endtask

  initial begin
    rstN = 1'b0; checkReq = 1'b0;
    clean();
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_no_fault();
    t_decode_undef();
    t_devna();
    t_align();
    t_prot_limit();
    t_real_limit();
    t_page();
    t_fp();
    t_timing();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule